// File: doc/BRIEF.md
# Remote Measurement Trigger Sequencer

This block paces measurements that an external host requests. When the host selects remote operation, a short active-low request pulse starts a sequence. The block first marks its data as not ready on a complementary pair of flag outputs. It then waits a settling time chosen by two range-select lines, and drives an active-low trigger to the meter. After the meter reports the end of its busy period, the block waits a fixed hold-off time. It then releases the trigger and the flag pair in the same cycle, which tells the host that fresh data is ready.

A bypass input skips the settling wait: the trigger and the flag are raised together. All inputs are asynchronous and pass through two-flop synchronizers. Delays are counted in clock cycles, derived from a clock-frequency parameter and a divisor that shortens every delay for quick runs.

Top module: `meas_trig_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to idle after that edge: `trigger_n`=1, `data_flag_p`=1, `data_flag_n`=0.
- R2: While `remote_n` is high (local operation), request pulses are ignored and the outputs stay idle.
- R3: With `remote_n` low, a high-to-low transition of `meas_req_n` drives `data_flag_p` low and `data_flag_n` high. This happens two synchronizer cycles plus one cycle after the input changes.
- R4: Once set, the data flag stays set after `meas_req_n` returns high, until the sequence ends.
- R5: With `trig_mode_n` high, `trigger_n` falls exactly N cycles after the data flag is set. N = round(T·CLK_HZ/TIME_DIV), with a minimum of 1. T is 33 s for `range_sel`=00, 3.3 s for 01, 0.42 s for 10 and 0.02 s for 11.
- R6: A falling edge of `meter_busy` starts a hold-off of P = round(0.04 s·CLK_HZ/TIME_DIV) cycles. P+3 cycles after the input falls, `trigger_n` rises and the flag pair returns to idle, all in the same cycle.
- R7: With `trig_mode_n` low when a request is accepted, `trigger_n` falls in the same cycle as the data flag is set.
- R8: A request that arrives while a sequence is running has no effect on its timing.
- R9: If `remote_n` goes high during a sequence, the outputs return to idle within 3 cycles and no trigger follows.
- R10: `range_sel` is sampled when the sequence starts. Changing it during the settling wait does not change that wait.
- R11: `data_flag_n` is always the complement of `data_flag_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| remote_n | input | 1 | Low selects remote operation (asynchronous) |
| meas_req_n | input | 1 | Active-low measurement request pulse (asynchronous) |
| trig_mode_n | input | 1 | Low bypasses the settling wait (asynchronous) |
| range_sel | input | 2 | Frequency range: 00 slowest to 11 fastest |
| meter_busy | input | 1 | High while the meter is measuring (asynchronous) |
| trigger_n | output | 1 | Active-low trigger to the meter |
| data_flag_p | output | 1 | Low while a measurement is pending |
| data_flag_n | output | 1 | High while a measurement is pending |

## Verification
The bench builds the block with CLK_HZ = 50,000,000 and TIME_DIV = 100,000. The four settling waits then become 16500, 1650, 210 and 10 cycles, and the hold-off becomes 20 cycles. Every range can therefore be measured to the exact cycle, and so can the hold-off. The same short waits leave room to put a second request, a range change or a drop of remote mode in the middle of a settling wait and still observe the outcome.

// File: rtl/mts_pkg.sv
// Shared types and delay arithmetic for the remote trigger sequencer.
// Assumes delays are expressed in units of 10 ms and scaled by a divisor.
package mts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_MEAS   = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;

    // Fixed hold-off after the meter finishes, in 10 ms units.
    localparam longint unsigned HOLD_UNITS = 64'd4;

    // Settling time for a range code, in 10 ms units (00 slowest).
    function automatic longint unsigned units_for_range(input logic [1:0] rsel);
        case (rsel)
            2'b00:   return 64'd3300;
            2'b01:   return 64'd330;
            2'b10:   return 64'd42;
            default: return 64'd2;
        endcase
    endfunction

    // Convert 10 ms units to clock cycles, never below one cycle.
    function automatic longint unsigned units_to_cycles(
        input longint unsigned clk_hz,
        input longint unsigned div,
        input longint unsigned units
    );
        longint unsigned cyc;
        cyc = (clk_hz * units + 64'd50 * div) / (64'd100 * div);
        if (cyc == 64'd0) cyc = 64'd1;
        return cyc;
    endfunction

endpackage

// File: rtl/mts_sync.sv
// Bank of two-flop synchronizers with a third flop that keeps the previous
// synchronized value for edge detection. Assumes each bit is independent.
module mts_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Capture, resolve and remember one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[b]   <= RST_VAL[b];
                q[b]      <= RST_VAL[b];
                q_prev[b] <= RST_VAL[b];
            end else begin
                meta[b]   <= d[b];
                q[b]      <= meta[b];
                q_prev[b] <= q[b];
            end
        end
    end
endmodule

// File: rtl/mts_timer.sv
// Down-counter for the settling and hold-off waits. A load of value V makes
// done rise V cycles later. Assumes V is at least one.
module mts_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val - CNT_W'(1);
        else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mts_ctrl.sv
// Sequencing state machine: holds the flag and trigger flip-flops and steps
// through settle, measure and hold-off. Assumes synchronized, edge-detected
// inputs and a timer that reports done V cycles after a load of V.
module mts_ctrl
    import mts_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 50_000_000,
    parameter longint unsigned TIME_DIV = 1,
    parameter int              CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             remote,
    input  logic             req_fall,
    input  logic             bypass,
    input  logic             busy_fall,
    input  logic [1:0]       range_sel,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             flag_q,
    output logic             trig_q
);
    localparam longint unsigned HOLD_CYC = units_to_cycles(CLK_HZ, TIME_DIV, HOLD_UNITS);

    seq_state_t state;
    logic       start;

    assign start = remote && req_fall && (state == ST_IDLE);

    // Choose what the timer loads: range settling at start, hold-off after busy.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(units_to_cycles(CLK_HZ, TIME_DIV, units_for_range(range_sel)));
        if (remote) begin
            if (start && !bypass) begin
                tmr_load = 1'b1;
            end else if (state == ST_MEAS && busy_fall) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HOLD_CYC);
            end
        end
    end

    // Advance the sequence and drive the flag and trigger flip-flops.
    always_ff @(posedge clk) begin
        if (!rst_n || !remote) begin
            state  <= ST_IDLE;
            flag_q <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    flag_q <= 1'b1;
                    if (bypass) begin
                        trig_q <= 1'b1;
                        state  <= ST_MEAS;
                    end else begin
                        state  <= ST_SETTLE;
                    end
                end
                ST_SETTLE: if (tmr_done) begin
                    trig_q <= 1'b1;
                    state  <= ST_MEAS;
                end
                ST_MEAS: if (busy_fall) begin
                    state <= ST_HOLD;
                end
                ST_HOLD: if (tmr_done) begin
                    flag_q <= 1'b0;
                    trig_q <= 1'b0;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_TRIG_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> flag_q);                                            // R7
    AST_LOCAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !remote |=> (!flag_q && !trig_q));                             // R9
    AST_FLAG_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(remote && req_fall));                  // R3
    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_q) |-> $fell(flag_q));                              // R6
    AST_NO_TRIG_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> !trig_q);                             // R5
    AST_BYPASS_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && $past(bypass)) |-> $rose(trig_q));           // R7
endmodule

// File: rtl/meas_trig_seq.sv
// Top of the remote measurement trigger sequencer. Synchronizes the
// asynchronous host and meter inputs, detects edges, and drives the active-low
// trigger and the complementary data-flag pair. Assumes range_sel is steady
// around the request.
module meas_trig_seq #(
    parameter longint unsigned CLK_HZ   = 50_000_000,
    parameter longint unsigned TIME_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       remote_n,
    input  logic       meas_req_n,
    input  logic       trig_mode_n,
    input  logic [1:0] range_sel,
    input  logic       meter_busy,
    output logic       trigger_n,
    output logic       data_flag_p,
    output logic       data_flag_n
);
    localparam longint unsigned MAX_CYC =
        mts_pkg::units_to_cycles(CLK_HZ, TIME_DIV, mts_pkg::units_for_range(2'b00));
    localparam int CNT_W  = $clog2(MAX_CYC + 64'd1);
    localparam int SYNC_W = 6;

    logic [SYNC_W-1:0] raw, sq, sp;
    logic              remote, req_fall, bypass, busy_fall;
    logic              tmr_load, tmr_done, flag_q, trig_q;
    logic [CNT_W-1:0]  tmr_val;

    assign raw = {range_sel, meter_busy, trig_mode_n, meas_req_n, remote_n};

    mts_sync #(.W(SYNC_W), .RST_VAL(6'b00_0_1_1_1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(sq), .q_prev(sp)
    );

    assign remote    = ~sq[0];
    assign req_fall  = sp[1] & ~sq[1];
    assign bypass    = ~sq[2];
    assign busy_fall = sp[3] & ~sq[3];

    mts_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    mts_ctrl #(.CLK_HZ(CLK_HZ), .TIME_DIV(TIME_DIV), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .remote(remote), .req_fall(req_fall),
        .bypass(bypass), .busy_fall(busy_fall), .range_sel(sq[5:4]),
        .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .flag_q(flag_q), .trig_q(trig_q)
    );

    assign trigger_n   = ~trig_q;
    assign data_flag_p = ~flag_q;
    assign data_flag_n = flag_q;

    AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        data_flag_p != data_flag_n);                                   // R11
endmodule

// File: tb/meas_trig_seq_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed
// timing measurements for each requirement.
module meas_trig_seq_tb_top;
    localparam longint unsigned CLK_HZ   = 50_000_000;
    localparam longint unsigned TIME_DIV = 100_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, remote_n = 1'b1, meas_req_n = 1'b1, trig_mode_n = 1'b1;
    logic [1:0] range_sel = 2'b00;
    logic meter_busy = 1'b0;
    logic trigger_n, data_flag_p, data_flag_n;

    int checks = 0, fails = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    meas_trig_seq #(.CLK_HZ(CLK_HZ), .TIME_DIV(TIME_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .remote_n(remote_n), .meas_req_n(meas_req_n),
        .trig_mode_n(trig_mode_n), .range_sel(range_sel), .meter_busy(meter_busy),
        .trigger_n(trigger_n), .data_flag_p(data_flag_p), .data_flag_n(data_flag_n)
    );

    function automatic int cyc_of(real sec);
        int c;
        c = $rtoi(sec * real'(CLK_HZ) / real'(TIME_DIV) + 0.5);
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int settle_exp(logic [1:0] r);
        case (r)
            2'b00:   return cyc_of(33.0);
            2'b01:   return cyc_of(3.3);
            2'b10:   return cyc_of(0.42);
            default: return cyc_of(0.02);
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int h_rem[3], h_req[3], h_tm[3], h_bsy[3], h_rg[3];
    int m_phase = 0, m_left = 0, m_flag = 0, m_trig = 0;
    bit m_ready = 0;

    always @(posedge clk) begin
        int rem, rfall, bfall, tm, rg;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                h_rem[i] = 1; h_req[i] = 1; h_tm[i] = 1; h_bsy[i] = 0; h_rg[i] = 0;
            end
            m_phase = 0; m_flag = 0; m_trig = 0; m_left = 0;
        end else begin
            rem   = (h_rem[1] == 0);
            rfall = (h_req[2] == 1 && h_req[1] == 0);
            bfall = (h_bsy[2] == 1 && h_bsy[1] == 0);
            tm    = h_tm[1];
            rg    = h_rg[1];
            if (!rem) begin
                m_phase = 0; m_flag = 0; m_trig = 0;
            end else begin
                case (m_phase)
                    0: if (rfall) begin
                        m_flag = 1;
                        if (tm == 0) begin m_trig = 1; m_phase = 2; end
                        else begin m_left = settle_exp(2'(rg)); m_phase = 1; end
                    end
                    1: begin
                        m_left--;
                        if (m_left == 0) begin m_trig = 1; m_phase = 2; end
                    end
                    2: if (bfall) begin m_left = cyc_of(0.04); m_phase = 3; end
                    default: begin
                        m_left--;
                        if (m_left == 0) begin m_flag = 0; m_trig = 0; m_phase = 0; end
                    end
                endcase
            end
            for (int i = 2; i > 0; i--) begin
                h_rem[i] = h_rem[i-1]; h_req[i] = h_req[i-1]; h_tm[i] = h_tm[i-1];
                h_bsy[i] = h_bsy[i-1]; h_rg[i] = h_rg[i-1];
            end
            h_rem[0] = remote_n; h_req[0] = meas_req_n; h_tm[0] = trig_mode_n;
            h_bsy[0] = meter_busy; h_rg[0] = range_sel;
        end
        m_ready = 1;
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (m_ready && !done_flag) begin
            string rq;
            rq = (m_phase == 0) ? "R2" : (m_phase == 1) ? "R5" : "R6";
            chk(trigger_n == !m_trig, rq, "model trigger_n", trigger_n, !m_trig);
            chk(data_flag_p == !m_flag, rq, "model data_flag_p", data_flag_p, !m_flag);
            chk(data_flag_n == !data_flag_p, "R11", "flag pair complement", data_flag_n, !data_flag_p);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run one sequence; disturb: 0 none, 1 second request, 2 range change.
    task automatic run_seq(input logic [1:0] rng, input bit byp, input int disturb, input string rq);
        int n, guard;
        range_sel = rng; trig_mode_n = !byp;
        step(4);
        meas_req_n = 1'b0;
        guard = 0;
        while (data_flag_p == 1'b1 && guard < 20) begin step(1); guard++; end
        meas_req_n = 1'b1;
        chk(data_flag_p == 0 && data_flag_n == 1, "R3", "flag set by request", data_flag_n, 1);
        n = 0;
        while (trigger_n == 1'b1 && n < 20000) begin
            step(1); n++;
            if (n == 5) chk(data_flag_p == 0, "R4", "flag held after request ends", data_flag_p, 0);
            if (n == 50 && disturb == 1) meas_req_n = 1'b0;
            if (n == 53 && disturb == 1) meas_req_n = 1'b1;
            if (n == 50 && disturb == 2) range_sel = 2'b00;
        end
        chk(n == (byp ? 0 : settle_exp(rng)), rq, "settle cycles", n, byp ? 0 : settle_exp(rng));
        step(5);
        meter_busy = 1'b1;
        step(30);
        chk(trigger_n == 0 && data_flag_p == 0, "R6", "held during busy", trigger_n, 0);
        meter_busy = 1'b0;
        n = 0;
        while (trigger_n == 1'b0 && n < 500) begin step(1); n++; end
        chk(n == cyc_of(0.04) + 3, "R6", "release delay after busy", n, cyc_of(0.04) + 3);
        chk(data_flag_p == 1 && data_flag_n == 0, "R6", "flag released with trigger", data_flag_p, 1);
        range_sel = 2'b00;
        step(10);
    endtask

    initial begin
        step(5);
        chk(trigger_n == 1 && data_flag_p == 1 && data_flag_n == 0, "R1", "reset idle", trigger_n, 1);
        rst_n = 1'b1;
        step(3);
        // local mode: request must be ignored
        meas_req_n = 1'b0; step(3); meas_req_n = 1'b1;
        step(20);
        chk(data_flag_p == 1 && trigger_n == 1, "R2", "request ignored in local", data_flag_p, 1);
        remote_n = 1'b0;
        step(5);
        run_seq(2'b00, 1'b0, 0, "R5");
        run_seq(2'b01, 1'b0, 0, "R5");
        run_seq(2'b10, 1'b0, 0, "R5");
        run_seq(2'b11, 1'b0, 0, "R5");
        run_seq(2'b00, 1'b1, 0, "R7");
        run_seq(2'b10, 1'b0, 1, "R8");
        run_seq(2'b10, 1'b0, 2, "R10");
        // drop remote in the middle of a settling wait
        range_sel = 2'b01; trig_mode_n = 1'b1;
        step(4);
        meas_req_n = 1'b0; step(3); meas_req_n = 1'b1;
        step(100);
        chk(data_flag_p == 0, "R9", "sequence running before drop", data_flag_p, 0);
        remote_n = 1'b1;
        step(3);
        chk(data_flag_p == 1 && trigger_n == 1, "R9", "idle after remote drop", data_flag_p, 1);
        step(1700);
        chk(trigger_n == 1, "R9", "no late trigger", trigger_n, 1);
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog expired (R1..all): actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule